// File: doc/BRIEF.md
# Beat Pattern Source and Integrity Checker

This block supplies write data to a memory traffic engine one bus beat at a time. It also checks the data that the engine reads back against the stream it expects. The pattern source has three variants. The first is a 31-bit pseudo-random sequence. The second repeats one 32-bit word on every beat. The third swaps between two 32-bit words from beat to beat. A 32-bit word always fills the whole bus by copying it into every 32-bit lane. The engine pulses `wr_adv` each time it takes a write beat, and `rd_valid` each time it delivers a read beat.

The read side holds its own copy of the pseudo-random source. That copy starts from the same seed as the write side and steps once per read beat, so a linear read of a block that was written earlier lines up beat for beat. A mismatch counts only in pseudo-random mode. In the other modes the block reports that checking is off. There are two error flags. The window flag can be cleared when a new measurement window opens. The sticky flag holds until the next test starts.

Top module: `pgc_top`

## Requirements
- R1: After reset the mode is pseudo-random, the first word is 0xCAFECAFE, the second word is 0xF00DF00D, `chk_on` is 1, and both error flags are 0.
- R2: In pseudo-random mode (mode code 0), `wr_data` is the next DATA_W bits of the sequence x^31+x^28+1. The sequence is produced by a 31-bit state s. The output bit is s[30]. The shift is s <= {s[29:0], s[30]^s[27]}. The first output bit goes to `wr_data[DATA_W-1]`. The beat shown after reset or `test_start` comes from state SEED. Each `wr_adv` moves to the following contiguous slice, and without `wr_adv` the beat holds.
- R3: In fixed mode (code 1), `wr_data` is the first word on every beat, and `wr_adv` does not change it.
- R4: In alternate mode (code 2), the beat shown after `test_start` is the first word. Every `wr_adv` swaps between the first and the second word.
- R5: A 32-bit word appears in every one of the DATA_W/32 lanes of `wr_data`.
- R6: `test_start` returns both the write and the read source to SEED, returns the alternate phase to the first word, clears both error flags, and discards a read beat that arrives in the same cycle.
- R7: Each `rd_valid` beat is compared with the next read-side slice of the sequence, starting from SEED. In pseudo-random mode a mismatch sets `err_live` and `err_sticky` after the clock edge that samples it, and a matching beat changes neither flag.
- R8: `win_clear` clears `err_live` and leaves `err_sticky` unchanged. A mismatch in the same cycle keeps `err_live` set.
- R9: In fixed and alternate mode `chk_on` is 0, and a mismatching read beat sets neither flag.
- R10: A mode write of code 3 is ignored, and the previous mode stays in effect.
- R11: `mode_we` loads `mode_in`. `word_we` loads both `word_a_in` and `word_b_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Load strobe for the mode |
| mode_in | input | 2 | Mode code: 0 pseudo-random, 1 fixed, 2 alternate |
| word_we | input | 1 | Load strobe for both pattern words |
| word_a_in | input | 32 | First pattern word |
| word_b_in | input | 32 | Second pattern word |
| test_start | input | 1 | Restarts the sources and clears both flags |
| win_clear | input | 1 | Opens a new measurement window (clears `err_live`) |
| wr_adv | input | 1 | The write beat on `wr_data` was taken |
| wr_data | output | DATA_W | Current write beat |
| rd_valid | input | 1 | A read beat is present on `rd_data` |
| rd_data | input | DATA_W | Read beat |
| chk_on | output | 1 | 1 when integrity is being checked |
| err_live | output | 1 | A mismatch was seen in the current window |
| err_sticky | output | 1 | A mismatch was seen since the test started |

## Verification
The bench builds the block with DATA_W = 128 and SEED = 0x2AAA5555. This is the narrowest width that must be supported. It still gives four lanes for the replication checks, and each beat consumes 128 sequence steps, so a few beats reach well past the 31-bit state length. The non-default seed shows that the restart value comes from the parameter. At this width, one corrupted bit in a read beat is an easy case to build for the flag-priority checks.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

   localparam int PRBS_LEN  = 31;
   localparam int PRBS_TAP  = 28;
   localparam int LANE_W    = 32;

   typedef enum logic [1:0] {
      PAT_PRBS  = 2'd0,
      PAT_FIXED = 2'd1,
      PAT_ALT   = 2'd2
   } pat_mode_e;

   // One step of the x^31 + x^28 + 1 shift register.
   function automatic logic [PRBS_LEN-1:0] prbs_step(input logic [PRBS_LEN-1:0] s);
      return {s[PRBS_LEN-2:0], s[PRBS_LEN-1] ^ s[PRBS_TAP-1]};
   endfunction

   function automatic logic mode_code_ok(input logic [1:0] code);
      return (code == PAT_PRBS) || (code == PAT_FIXED) || (code == PAT_ALT);
   endfunction

endpackage

// File: rtl/pgc_prbs_gen.sv
module pgc_prbs_gen
   import pgc_pkg::*;
#(
   parameter int                    W    = 512,
   parameter logic [PRBS_LEN-1:0]   SEED = 31'h2EED1234
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         advance,
   output logic [W-1:0] beat
);

   logic [PRBS_LEN-1:0] state_q;
   logic [PRBS_LEN-1:0] state_nx;

   // Unroll W steps: the beat is the next W output bits, MSB first.
   always_comb begin
      logic [PRBS_LEN-1:0] s;
      s    = state_q;
      beat = '0;
      for (int k = 0; k < W; k++) begin
         beat[W-1-k] = s[PRBS_LEN-1];
         s           = prbs_step(s);
      end
      state_nx = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q <= SEED;
      else if (restart) state_q <= SEED;
      else if (advance) state_q <= state_nx;
   end

endmodule

// File: rtl/pgc_word_fill.sv
module pgc_word_fill
   import pgc_pkg::*;
#(
   parameter int W = 512
)(
   input  logic [LANE_W-1:0] word,
   output logic [W-1:0]      bus
);

   localparam int LANES = W / LANE_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign bus[g*LANE_W +: LANE_W] = word;
   end

endmodule

// File: rtl/pgc_err_track.sv
module pgc_err_track (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic win_clear,
   input  logic beat_err,
   output logic err_live,
   output logic err_sticky
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_live   <= 1'b0;
         err_sticky <= 1'b0;
      end else if (restart) begin
         err_live   <= 1'b0;
         err_sticky <= 1'b0;
      end else begin
         if (beat_err)       err_live <= 1'b1;
         else if (win_clear) err_live <= 1'b0;
         if (beat_err)       err_sticky <= 1'b1;
      end
   end

endmodule

// File: rtl/pgc_top.sv
module pgc_top
   import pgc_pkg::*;
#(
   parameter int                  DATA_W     = 512,
   parameter logic [PRBS_LEN-1:0] SEED       = 31'h2EED1234,
   parameter logic [LANE_W-1:0]   WORD_A_RST = 32'hCAFECAFE,
   parameter logic [LANE_W-1:0]   WORD_B_RST = 32'hF00DF00D
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [1:0]        mode_in,
   input  logic              word_we,
   input  logic [31:0]       word_a_in,
   input  logic [31:0]       word_b_in,
   input  logic              test_start,
   input  logic              win_clear,
   input  logic              wr_adv,
   output logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              chk_on,
   output logic              err_live,
   output logic              err_sticky
);

   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0 || LANES < 1) begin : g_bad_width
      $error("pgc_top: DATA_W must be a non-zero multiple of 32");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("pgc_top: SEED must not be zero");
   end

   pat_mode_e           mode_q;
   logic [LANE_W-1:0]   word_a_q, word_b_q;
   logic                alt_phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= PAT_PRBS;
         word_a_q <= WORD_A_RST;
         word_b_q <= WORD_B_RST;
      end else begin
         if (mode_we && mode_code_ok(mode_in)) mode_q <= pat_mode_e'(mode_in);
         if (word_we) begin
            word_a_q <= word_a_in;
            word_b_q <= word_b_in;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          alt_phase_q <= 1'b0;
      else if (test_start) alt_phase_q <= 1'b0;
      else if (wr_adv)     alt_phase_q <= ~alt_phase_q;
   end

   // Write side
   logic [DATA_W-1:0] wr_prbs, wr_word_bus;
   logic [LANE_W-1:0] wr_word;

   pgc_prbs_gen #(.W(DATA_W), .SEED(SEED)) u_wr_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (test_start),
      .advance (wr_adv),
      .beat    (wr_prbs)
   );

   assign wr_word = (mode_q == PAT_ALT && alt_phase_q) ? word_b_q : word_a_q;

   pgc_word_fill #(.W(DATA_W)) u_fill (
      .word (wr_word),
      .bus  (wr_word_bus)
   );

   assign wr_data = (mode_q == PAT_PRBS) ? wr_prbs : wr_word_bus;

   // Read side
   logic [DATA_W-1:0] rd_exp;
   logic              rd_take;
   logic              beat_err;

   assign rd_take = rd_valid && !test_start;

   pgc_prbs_gen #(.W(DATA_W), .SEED(SEED)) u_rd_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (test_start),
      .advance (rd_take),
      .beat    (rd_exp)
   );

   assign chk_on   = (mode_q == PAT_PRBS);
   assign beat_err = rd_take && chk_on && (rd_data != rd_exp);

   pgc_err_track u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (test_start),
      .win_clear  (win_clear),
      .beat_err   (beat_err),
      .err_live   (err_live),
      .err_sticky (err_sticky)
   );

endmodule

// File: rtl/pgc_top_chk.sv
module pgc_top_chk #(
   parameter int W = 512
)(
   input logic         clk,
   input logic         rst_n,
   input logic         test_start,
   input logic         mode_we,
   input logic         word_we,
   input logic         wr_adv,
   input logic [1:0]   mode_q,
   input logic [31:0]  word_a_q,
   input logic [31:0]  word_b_q,
   input logic [W-1:0] wr_data,
   input logic         chk_on,
   input logic         err_live,
   input logic         err_sticky
);

   a_r10_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != 2'd3);

   a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      test_start |=> (!err_live && !err_sticky));

   a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !test_start) |=> err_sticky);

   a_r7_live_within_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_live |-> err_sticky);

   a_r9_unchecked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_on && !err_sticky && !test_start) |=> !err_sticky);

   a_r3_fixed_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd1 && !mode_we && !word_we) |=> $stable(wr_data));

   a_r4_alt_swaps: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd2 && wr_adv && !test_start && !mode_we && !word_we &&
       word_a_q != word_b_q && wr_data[31:0] == word_a_q) |=> wr_data[31:0] == word_b_q);

endmodule

bind pgc_top pgc_top_chk #(.W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .test_start (test_start),
   .mode_we    (mode_we),
   .word_we    (word_we),
   .wr_adv     (wr_adv),
   .mode_q     (mode_q),
   .word_a_q   (word_a_q),
   .word_b_q   (word_b_q),
   .wr_data    (wr_data),
   .chk_on     (chk_on),
   .err_live   (err_live),
   .err_sticky (err_sticky)
);

// File: tb/sim_pgc_top.sv
module sim_pgc_top;

   localparam int          W    = 128;
   localparam logic [30:0] SEED = 31'h2AAA5555;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_we = 1'b0;
   logic [1:0]   mode_in = '0;
   logic         word_we = 1'b0;
   logic [31:0]  word_a_in = '0, word_b_in = '0;
   logic         test_start = 1'b0, win_clear = 1'b0, wr_adv = 1'b0;
   logic [W-1:0] wr_data;
   logic         rd_valid = 1'b0;
   logic [W-1:0] rd_data = '0;
   logic         chk_on, err_live, err_sticky;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #4 clk = ~clk;

   pgc_top #(.DATA_W(W), .SEED(SEED)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
      .word_we(word_we), .word_a_in(word_a_in), .word_b_in(word_b_in),
      .test_start(test_start), .win_clear(win_clear), .wr_adv(wr_adv),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .chk_on(chk_on), .err_live(err_live), .err_sticky(err_sticky)
   );

   // Stimulus table: {mode, first word, second word}
   localparam logic [65:0] VEC [4] = '{
      {2'd1, 32'h12345678, 32'h00000000},
      {2'd2, 32'hFFFFFFFF, 32'h00000000},
      {2'd2, 32'hA5A5A5A5, 32'h5A5A5A5A},
      {2'd1, 32'h000000AB, 32'hDEADBEEF}
   };

   function automatic logic [W-1:0] m_beat(input logic [30:0] s_in);
      logic [30:0] s = s_in;
      logic [W-1:0] b;
      for (int k = 0; k < W; k++) begin
         b[W-1-k] = s[30];
         s = {s[29:0], s[30] ^ s[27]};
      end
      return b;
   endfunction

   function automatic logic [30:0] m_next(input logic [30:0] s_in);
      logic [30:0] s = s_in;
      for (int k = 0; k < W; k++) s = {s[29:0], s[30] ^ s[27]};
      return s;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
      mode_we = 0; word_we = 0; test_start = 0; win_clear = 0;
      wr_adv = 0; rd_valid = 0;
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [30:0]  ws, rs;
      logic [W-1:0] exp;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 / R2: reset state
      check("R1 chk_on", W'(chk_on), W'(1));
      check("R1 err_live", W'(err_live), '0);
      check("R1 err_sticky", W'(err_sticky), '0);
      check("R2 reset beat", wr_data, m_beat(SEED));

      // R1 / R3 / R5: default words in fixed mode
      mode_we = 1; mode_in = 2'd1; tick();
      check("R1 R3 default first word", wr_data, {4{32'hCAFECAFE}});
      check("R9 chk_on fixed", W'(chk_on), '0);
      // R1 / R4: default words in alternate mode
      mode_we = 1; mode_in = 2'd2; test_start = 1; tick();
      check("R4 alt first", wr_data, {4{32'hCAFECAFE}});
      wr_adv = 1; tick();
      check("R1 R4 default second word", wr_data, {4{32'hF00DF00D}});

      // R3 / R4 / R5 / R11: table walk
      foreach (VEC[i]) begin
         mode_we = 1; mode_in = VEC[i][65:64];
         word_we = 1; word_a_in = VEC[i][63:32]; word_b_in = VEC[i][31:0];
         test_start = 1; tick();
         for (int j = 0; j < 4; j++) begin
            if (VEC[i][65:64] == 2'd1 || j % 2 == 0) exp = {4{VEC[i][63:32]}};
            else exp = {4{VEC[i][31:0]}};
            check(VEC[i][65:64] == 2'd1 ? "R3 R5 R11 fixed beat" : "R4 R5 R11 alt beat",
                  wr_data, exp);
            wr_adv = 1; tick();
         end
      end

      // R10: code 3 ignored (mode stays alternate)
      word_we = 1; word_a_in = 32'h11111111; word_b_in = 32'h22222222;
      mode_we = 1; mode_in = 2'd2; test_start = 1; tick();
      mode_we = 1; mode_in = 2'd3; tick();
      check("R10 mode kept", wr_data, {4{32'h11111111}});
      wr_adv = 1; tick();
      check("R10 still alternating", wr_data, {4{32'h22222222}});

      // R2: pseudo-random write beats
      mode_we = 1; mode_in = 2'd0; test_start = 1; tick();
      ws = SEED;
      check("R2 R6 beat 0", wr_data, m_beat(ws));
      for (int j = 1; j < 6; j++) begin
         wr_adv = 1; tick();
         ws = m_next(ws);
         check("R2 beat", wr_data, m_beat(ws));
      end
      tick();
      check("R2 hold without advance", wr_data, m_beat(ws));
      test_start = 1; tick();
      check("R6 write restart", wr_data, m_beat(SEED));

      // R7: read loopback
      rs = SEED;
      for (int j = 0; j < 4; j++) begin
         rd_valid = 1; rd_data = m_beat(rs); tick();
         rs = m_next(rs);
         check("R7 good beat live", W'(err_live), '0);
      end
      check("R7 good beats sticky", W'(err_sticky), '0);
      rd_valid = 1; rd_data = m_beat(rs) ^ {{(W-1){1'b0}}, 1'b1}; tick();
      rs = m_next(rs);
      check("R7 mismatch live", W'(err_live), W'(1));
      check("R7 mismatch sticky", W'(err_sticky), W'(1));
      rd_valid = 1; rd_data = m_beat(rs); tick();
      rs = m_next(rs);
      check("R7 live holds in window", W'(err_live), W'(1));
      // R8
      win_clear = 1; tick();
      check("R8 window clears live", W'(err_live), '0);
      check("R8 sticky kept", W'(err_sticky), W'(1));
      win_clear = 1; rd_valid = 1; rd_data = ~m_beat(rs); tick();
      rs = m_next(rs);
      check("R8 error beats clear", W'(err_live), W'(1));
      // R6
      test_start = 1; rd_valid = 1; rd_data = '0; tick();
      check("R6 restart live", W'(err_live), '0);
      check("R6 restart sticky", W'(err_sticky), '0);
      rd_valid = 1; rd_data = m_beat(SEED); tick();
      check("R6 read restart aligned", W'(err_sticky), '0);

      // R9: unchecked modes
      mode_we = 1; mode_in = 2'd1; test_start = 1; tick();
      rd_valid = 1; rd_data = {4{32'hBADBAD00}}; tick();
      check("R9 fixed no live", W'(err_live), '0);
      check("R9 fixed no sticky", W'(err_sticky), '0);
      mode_we = 1; mode_in = 2'd2; tick();
      check("R9 chk_on alt", W'(chk_on), '0);
      rd_valid = 1; rd_data = '1; tick();
      check("R9 alt no sticky", W'(err_sticky), '0);

      done = 1;
      summary();
      $finish;
   end

endmodule